// File: doc/BRIEF.md
# Digit-Serial BCD Adder-Subtractor

This block adds or subtracts two packed BCD numbers of `K_DIGITS` decimal digits. Both operands and the mode are captured on a start pulse. The block then works through them one digit per clock, from the least significant digit upward. A single decimal carry flip-flop links each digit to the next.

Each digit goes through a 4-bit binary adder and then a correction stage. The correction stage adds six whenever the raw sum passes nine, and it also produces the decimal carry. For subtraction, each digit of B is replaced by its nines' complement (9 − B) and the carry flip-flop is preset to one. The sum is then A plus the tens' complement of B.

When the last digit has been written, a one-cycle done pulse marks the result, the carry and the flags as valid. They stay valid until the next start.

Top module: `bcd_serial_addsub`

## Requirements
- R1: After a synchronous active-low reset, busy, done, result, carry_out, overflow and invalid are all 0.
- R2: A start sampled while busy is low loads both operands and the mode. Busy is then high for exactly K_DIGITS cycles, and done is high for one cycle beginning at the K_DIGITS-th rising edge after the start edge.
- R3: With sub_mode = 0, result holds (A + B) mod 10^K_DIGITS as packed BCD. Digit i sits in bits [4i+3:4i] and digit 0 is least significant. carry_out is 1 exactly when A + B ≥ 10^K_DIGITS, and overflow equals carry_out.
- R4: With sub_mode = 1, result holds (A − B) mod 10^K_DIGITS, which is the tens' complement when A < B. carry_out is 1 exactly when A ≥ B, and overflow stays 0.
- R5: In subtract mode each B digit d is replaced by 9 − d before it is added, with an initial carry of 1. For example, 0 − 1 gives all nines with carry_out 0, and equal operands give zero with carry_out 1.
- R6: A decimal carry out of one digit adds into the next digit in the following cycle. For example, 9999 + 0001 gives 0000 with carry_out and overflow at 1.
- R7: invalid is 1 with done when any digit of A or B at start is above 9. It is 0 when all digits are valid, and it holds that value until the next start.
- R8: A start asserted while busy is high is ignored. The running operation finishes with its own operands and its own timing.
- R9: Between done and the next start, result, carry_out, overflow and invalid do not change, and done stays low.
- R10: A digit whose binary sum is 16 to 19 (for example 9 + 9 + 1) is corrected to the right decimal digit and produces a carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| sub_mode | input | 1 | 0 = add, 1 = subtract A − B |
| a_bcd | input | 4*K_DIGITS | Operand A, packed BCD |
| b_bcd | input | 4*K_DIGITS | Operand B, packed BCD |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: outputs valid |
| result | output | 4*K_DIGITS | Packed BCD result |
| carry_out | output | 1 | Final decimal carry (subtract: 1 means A ≥ B) |
| overflow | output | 1 | Add-mode carry out of the top digit |
| invalid | output | 1 | An operand digit above 9 was seen at start |

## Verification
The bench targets the correction boundary. 9 + 9 + 1 gives a binary sum of 19, so a design that tests only for a sum above 9, or that drops the fifth sum bit, emits a wrong digit. Chains such as 9999 + 0001 and 0000 − 0001 catch a carry flip-flop that is not carried between digits or not preset in subtract mode; that fault shows up as a result off by one or a wrong sign carry. A second start issued mid-operation, and checks of the done latency, expose a controller that reloads while busy or that is off by one cycle. A flag test with a digit of 0xA followed by a clean operation catches an invalid flag that never sets or never clears.

// File: rtl/bcd_arith_pkg.sv
// Package: shared types and helpers for the digit-serial BCD unit.
// Assumes 4-bit packed BCD digits.
package bcd_arith_pkg;

    localparam int unsigned DIGIT_W = 4;
    localparam logic [3:0]  DEC_MAX = 4'd9;

    // Sequencer state.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // True when a 4-bit code is a legal decimal digit.
    function automatic logic digit_is_bcd(input logic [3:0] d);
        return (d <= DEC_MAX);
    endfunction

endpackage

// File: rtl/bcd_nines_comp.sv
// Module: bcd_nines_comp
// Forms the nines' complement (9 - d) of one BCD digit when enable is high,
// otherwise passes the digit through. COMP_STYLE picks the gate structure:
//   0 : bitwise inverse of (d + 0110)
//   1 : bitwise inverse of d, plus 1010, carry dropped
// Assumes a legal digit; an illegal digit gives an unspecified code.
module bcd_nines_comp #(
    parameter int unsigned COMP_STYLE = 0
) (
    input  logic [3:0] digit_in,
    input  logic       enable,
    output logic [3:0] digit_out
);

    logic [3:0] comp;

    generate
        if (COMP_STYLE == 0) begin : g_inv_of_sum
            logic [3:0] biased;
            // Bias by six, then invert: 15 - (d + 6) = 9 - d.
            assign biased = digit_in + 4'd6;
            assign comp   = ~biased;
        end else begin : g_inv_plus_ten
            // Invert, then add ten modulo 16: (15 - d) + 10 - 16 = 9 - d.
            assign comp = (~digit_in) + 4'd10;
        end
    endgenerate

    // Select the complemented or the original digit.
    always_comb begin
        digit_out = enable ? comp : digit_in;
    end

endmodule

// File: rtl/bcd_digit_adder.sv
// Module: bcd_digit_adder
// One decimal digit position: a 4-bit binary add with carry-in, followed by a
// +6 correction when the 5-bit binary sum exceeds 9. The correction condition
// is also the decimal carry out. Assumes both inputs are legal digits.
module bcd_digit_adder (
    input  logic [3:0] x_dig,
    input  logic [3:0] y_dig,
    input  logic       c_in,
    output logic [3:0] s_dig,
    output logic       c_out
);

    logic [4:0] bin_sum;
    logic       fix;

    // Raw binary sum, keeping the fifth bit so that sums of 16..19 are seen.
    always_comb begin
        bin_sum = {1'b0, x_dig} + {1'b0, y_dig} + {4'b0000, c_in};
    end

    // Correction stage: add 0110 on a decimal overflow.
    always_comb begin
        fix   = (bin_sum > 5'd9);
        s_dig = fix ? (bin_sum[3:0] + 4'd6) : bin_sum[3:0];
        c_out = fix;
    end

endmodule

// File: rtl/bcd_operand_check.sv
// Module: bcd_operand_check
// Flags any digit above 9 in either packed operand. Purely combinational;
// one comparator per digit.
module bcd_operand_check
    import bcd_arith_pkg::*;
#(
    parameter int unsigned K_DIGITS = 4,
    localparam int unsigned W       = 4 * K_DIGITS
) (
    input  logic [W-1:0] a_vec,
    input  logic [W-1:0] b_vec,
    output logic         any_bad
);

    logic [K_DIGITS-1:0] bad_a;
    logic [K_DIGITS-1:0] bad_b;

    generate
        for (genvar i = 0; i < K_DIGITS; i++) begin : g_digit
            // Per-digit legality test on each operand.
            assign bad_a[i] = !digit_is_bcd(a_vec[4*i +: 4]);
            assign bad_b[i] = !digit_is_bcd(b_vec[4*i +: 4]);
        end
    endgenerate

    // Reduce to a single flag.
    always_comb begin
        any_bad = (|bad_a) | (|bad_b);
    end

endmodule

// File: rtl/bcd_seq_ctrl.sv
// Module: bcd_seq_ctrl
// Sequencer for the digit-serial datapath. In idle it accepts start and
// raises load. It then issues K_DIGITS step cycles, marks the last one, and
// pulses done in the cycle after the last step. A start seen while running is
// ignored.
module bcd_seq_ctrl
    import bcd_arith_pkg::*;
#(
    parameter int unsigned K_DIGITS = 4,
    localparam int unsigned CNT_W   = (K_DIGITS > 1) ? $clog2(K_DIGITS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(K_DIGITS - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Decode the strobes for the datapath.
    always_comb begin
        busy = (state == SEQ_RUN);
        load = start && (state == SEQ_IDLE);
        step = busy;
        last = busy && (cnt == LAST_IDX);
    end

    // State, digit counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_RUN;
                        cnt   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (cnt == LAST_IDX) begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bcd_serial_addsub.sv
// Module: bcd_serial_addsub (top)
// Digit-serial packed-BCD adder-subtractor. On an accepted start it captures
// the operands and mode, then processes one digit per clock, least significant
// first. Each new result digit enters the top of a result shift register, so
// after K_DIGITS steps the result is aligned. Subtraction adds the nines'
// complement of B with the carry preset to 1. Result and flags are valid from
// done until the next start. Assumes operands are held only for the start
// cycle.
module bcd_serial_addsub
    import bcd_arith_pkg::*;
#(
    parameter int unsigned K_DIGITS   = 4,
    parameter int unsigned COMP_STYLE = 0,
    localparam int unsigned W         = 4 * K_DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sub_mode,
    input  logic [W-1:0] a_bcd,
    input  logic [W-1:0] b_bcd,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow,
    output logic         invalid
);

    logic         load, step, last;
    logic [W-1:0] a_sh, b_sh, res_sh;
    logic         carry_q, sub_q, cout_q, inv_q;
    logic         op_bad;
    logic [3:0]   b_eff, dig_sum;
    logic         dig_cout;
    logic [W+3:0] res_cat;

    // Sequencer.
    bcd_seq_ctrl #(.K_DIGITS(K_DIGITS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    // Operand legality check at load time.
    bcd_operand_check #(.K_DIGITS(K_DIGITS)) u_chk_in (
        .a_vec   (a_bcd),
        .b_vec   (b_bcd),
        .any_bad (op_bad)
    );

    // Nines' complement of the current B digit in subtract mode.
    bcd_nines_comp #(.COMP_STYLE(COMP_STYLE)) u_comp (
        .digit_in  (b_sh[3:0]),
        .enable    (sub_q),
        .digit_out (b_eff)
    );

    // Single decimal digit adder with correction.
    bcd_digit_adder u_add (
        .x_dig (a_sh[3:0]),
        .y_dig (b_eff),
        .c_in  (carry_q),
        .s_dig (dig_sum),
        .c_out (dig_cout)
    );

    // New digit enters the top of the result register.
    always_comb begin
        res_cat = {dig_sum, res_sh};
    end

    // Operand and result shift registers, carry flip-flop and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sh    <= '0;
            b_sh    <= '0;
            res_sh  <= '0;
            carry_q <= 1'b0;
            sub_q   <= 1'b0;
            cout_q  <= 1'b0;
            inv_q   <= 1'b0;
        end else if (load) begin
            a_sh    <= a_bcd;
            b_sh    <= b_bcd;
            carry_q <= sub_mode;
            sub_q   <= sub_mode;
            cout_q  <= 1'b0;
            inv_q   <= op_bad;
        end else if (step) begin
            a_sh    <= a_sh >> 4;
            b_sh    <= b_sh >> 4;
            res_sh  <= res_cat[W+3:4];
            carry_q <= dig_cout;
            if (last) begin
                cout_q <= dig_cout;
            end
        end
    end

    // Drive the result and status outputs.
    always_comb begin
        result    = res_sh;
        carry_out = cout_q;
        overflow  = cout_q & ~sub_q;
        invalid   = inv_q;
    end

endmodule

// File: rtl/bcd_serial_addsub_chk.sv
// Module: bcd_serial_addsub_chk
// Property checker for bcd_serial_addsub, bound into every instance.
module bcd_serial_addsub_chk
    import bcd_arith_pkg::*;
#(
    parameter int unsigned K_DIGITS = 4,
    localparam int unsigned W       = 4 * K_DIGITS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         overflow,
    input logic         invalid,
    input logic         sub_q,
    input logic [3:0]   dig_a,
    input logic [3:0]   dig_b,
    input logic [3:0]   dig_sum
);

    // R2: done lasts a single cycle.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done is never raised while busy.
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: an accepted start makes the unit busy.
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: overflow is an add-mode carry only.
    a_r4_no_sub_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (carry_out && !sub_q));

    // R9: outputs hold while idle with no start.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result) && $stable(carry_out) && $stable(invalid)));

    // R10: legal input digits always give a legal sum digit.
    a_r10_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && digit_is_bcd(dig_a) && digit_is_bcd(dig_b)) |-> digit_is_bcd(dig_sum));

endmodule

bind bcd_serial_addsub bcd_serial_addsub_chk #(.K_DIGITS(K_DIGITS)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .invalid   (invalid),
    .sub_q     (sub_q),
    .dig_a     (a_sh[3:0]),
    .dig_b     (b_sh[3:0]),
    .dig_sum   (dig_sum)
);

// File: tb/tb_bcd_serial_addsub.sv
`timescale 1ns/1ps
module tb_bcd_serial_addsub;

    localparam int K = 4;
    localparam int W = 4 * K;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sub_mode = 1'b0;
    logic [W-1:0] a_bcd = '0;
    logic [W-1:0] b_bcd = '0;
    logic         busy, done, carry_out, overflow, invalid;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int modulus;

    always #4 clk = ~clk;

    bcd_serial_addsub #(.K_DIGITS(K)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_mode(sub_mode),
        .a_bcd(a_bcd), .b_bcd(b_bcd), .busy(busy), .done(done),
        .result(result), .carry_out(carry_out), .overflow(overflow),
        .invalid(invalid)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r = '0;
        int t = v;
        for (int i = 0; i < K; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one operation; optionally inject a second start mid-run.
    task automatic exec(input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic sm, input bit inject, output int cyc);
        @(negedge clk);
        a_bcd = av; b_bcd = bv; sub_mode = sm; start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (inject && cyc == 2) begin
                a_bcd = to_bcd(1111); b_bcd = to_bcd(2222);
                sub_mode = ~sm; start = 1'b1;
            end
        end while (!done && cyc < 50);
        start = 1'b0;
    endtask

    // Run a valid decimal operation and check against the model.
    task automatic run_op(input int av, input int bv, input logic sm,
                          input string req, input bit inject);
        int cyc, exp_res;
        bit exp_c;
        exec(to_bcd(av), to_bcd(bv), sm, inject, cyc);
        if (sm) begin
            exp_res = (av - bv + modulus) % modulus;
            exp_c   = (av >= bv);
        end else begin
            exp_res = (av + bv) % modulus;
            exp_c   = (av + bv >= modulus);
        end
        chk(cyc == K + 1, "R2", {req, " latency"}, cyc, K + 1);
        chk(result == to_bcd(exp_res), req, "result", result, to_bcd(exp_res));
        chk(carry_out == exp_c, req, "carry_out", carry_out, exp_c);
        chk(overflow == (exp_c && !sm), req, "overflow", overflow, exp_c && !sm);
        chk(invalid == 1'b0, "R7", {req, " invalid clear"}, invalid, 0);
    endtask

    task automatic t_reset;
        chk(!busy && !done && result == '0 && !carry_out && !overflow && !invalid,
            "R1", "reset state", {busy, done, carry_out, overflow, invalid, result}, 0);
    endtask

    task automatic t_invalid;
        int cyc;
        exec(16'h12A4, to_bcd(11), 1'b0, 1'b0, cyc);
        chk(invalid == 1'b1, "R7", "bad A digit", invalid, 1);
        exec(to_bcd(5), 16'hF000, 1'b1, 1'b0, cyc);
        chk(invalid == 1'b1, "R7", "bad B digit", invalid, 1);
        run_op(10, 20, 1'b0, "R7", 1'b0);
    endtask

    task automatic t_hold;
        logic [W-1:0] r0;
        bit c0;
        run_op(8765, 4321, 1'b1, "R4", 1'b0);
        r0 = result; c0 = carry_out;
        repeat (4) @(negedge clk);
        chk(result == r0 && carry_out == c0 && !done && !busy, "R9", "hold after done",
            {result, carry_out, done}, {r0, c0, 1'b0});
    endtask

    initial begin
        modulus = 1;
        for (int i = 0; i < K; i++) modulus = modulus * 10;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_op(1234, 4321, 1'b0, "R3", 1'b0);
        run_op(456, 789, 1'b0, "R6", 1'b0);
        run_op(9999, 1, 1'b0, "R6", 1'b0);
        run_op(9999, 9999, 1'b0, "R10", 1'b0);
        run_op(5000, 1234, 1'b1, "R4", 1'b0);
        run_op(1234, 5000, 1'b1, "R4", 1'b0);
        run_op(0, 1, 1'b1, "R5", 1'b0);
        run_op(7777, 7777, 1'b1, "R5", 1'b0);
        run_op(9, 9, 1'b0, "R10", 1'b0);
        t_invalid();
        run_op(3141, 2718, 1'b0, "R8", 1'b1);
        run_op(2718, 3141, 1'b1, "R8", 1'b1);
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule